// File: doc/BRIEF.md
# Resonant Actuator Drive Phase Sequencer

This block drives a linear resonant actuator through an H-bridge. A level-sensitive enable input starts and stops vibration. The block turns that input into a timed run of four phases: idle, a full-strength start-up, a steady drive at a programmed amplitude, and a brake. Two bridge control outputs toggle in antiphase at a drive frequency chosen by a code. A prescaled tick sets the time base for every duration.

The brake length follows the burst that came before it. By default it equals the time spent in start-up and drive, capped at a maximum (30 ms at the default tick). A non-zero brake setting replaces that rule with a fixed length. An enable edge that arrives while the brake runs is remembered, and a new start-up begins as soon as the brake ends. A very short enable pulse still produces one complete drive period. For a settling window after reset the enable input has no effect. Configuration inputs are expected to stay stable while the block is not idle. The enable input must be synchronous to `clk`.

Top module: `lra_drive_seq`

## Requirements
- R1: After reset the phase output reads idle (phase encoding: 0 idle, 1 start-up, 2 drive, 3 brake), and both bridge outputs and the amplitude output are 0. They stay 0 whenever the phase is idle.
- R2: For LOCK_TICKS ticks after reset, enable is ignored, including edges. The phase stays idle whatever the enable does.
- R3: From idle, a tick that sees enable high, or a latched enable edge, moves the phase to start-up. With enable held high, start-up lasts max(startup_per_i,1) drive periods, and the amplitude output is all ones.
- R4: Start-up is followed by drive while enable stays high, with the amplitude output equal to amp_cfg_i. Drive ends at the first period boundary at which enable is low, and the phase then moves to brake.
- R5: An enable pulse shorter than one drive period, even a single clock, yields exactly one full period of start-up followed by brake.
- R6: One drive period is 2*H ticks, where H = HALF_MIN + freq_code_i*HALF_STEP. In the first half only hb_a_o may be high; in the second half only hb_b_o may be high. The first tick of each half has both outputs low.
- R7: hb_a_o and hb_b_o are never high in the same cycle.
- R8: With brake_cfg_i = 0, brake lasts min(D, BRAKE_CAP) ticks, where D is the number of ticks spent in start-up plus drive.
- R9: With brake_cfg_i non-zero, brake lasts exactly brake_cfg_i ticks.
- R10: In brake, the first tick has both outputs low. After that hb_a_o is high, which is the opposite of the last drive half, and hb_b_o stays low. The amplitude output is all ones.
- R11: An enable rising edge during brake, including in its last cycle, makes the block go straight from brake to start-up. Without such an edge the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Vibration enable, level sensitive, synchronous to clk |
| startup_per_i | input | SU_W | Start-up length in drive periods (0 treated as 1) |
| brake_cfg_i | input | CNT_W | Brake length in ticks; 0 selects the adaptive length |
| amp_cfg_i | input | AMP_W | Amplitude code used in steady drive |
| freq_code_i | input | FC_W | Drive frequency code, selects the half period |
| hb_a_o | output | 1 | Bridge control, first half-period polarity |
| hb_b_o | output | 1 | Bridge control, second half-period polarity |
| amp_o | output | AMP_W | Amplitude applied to the bridge |
| phase_o | output | 2 | Current phase code |

## Verification
The end of a brake and a fresh enable edge can fall in the same cycle. The latched-edge path and the brake-exit decision then act together. The bench pulses enable while a brake is running. A scoreboard of expected phase segments requires brake to be followed directly by a one-period start-up with no idle segment between them. That start-up's own brake must then have the adaptive length derived from that single period. A period-boundary stop also coincides with the sampling of a low enable, so the bench places enable falls at known offsets from the boundaries. It then judges the measured drive length as a whole number of periods.

// File: rtl/lra_seq_pkg.sv
package lra_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DRIVE = 2'd2,
    PH_BRAKE = 2'd3
  } phase_e;
endpackage

// File: rtl/lra_tick_gen.sv
module lra_tick_gen #(
  parameter int TICK_DIV = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q + DIV_W'(1);
        if (cnt_q == LAST) cnt_d = '0;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end

      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/lra_lockout.sv
module lra_lockout #(
  parameter int LOCK_TICKS = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic ready_o
);
  localparam int LK_W = $clog2(LOCK_TICKS + 1);
  localparam logic [LK_W-1:0] LOCK_V = LK_W'(LOCK_TICKS);

  logic [LK_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i && (cnt_q != LOCK_V)) cnt_d = cnt_q + LK_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q == LOCK_V);
endmodule

// File: rtl/lra_wave_gen.sv
module lra_wave_gen #(
  parameter int FC_W      = 5,
  parameter int CNT_W     = 16,
  parameter int HALF_MIN  = 130,
  parameter int HALF_STEP = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [FC_W-1:0]  freq_code_i,
  output logic             pol_a_o,
  output logic             pol_b_o,
  output logic             period_end_o
);
  logic [CNT_W-1:0] half_len;

  generate
    if (HALF_STEP == 1) begin : g_unit
      assign half_len = CNT_W'(HALF_MIN) + CNT_W'(freq_code_i);
    end else begin : g_scaled
      assign half_len = CNT_W'(HALF_MIN) + CNT_W'(freq_code_i) * CNT_W'(HALF_STEP);
    end
  endgenerate

  logic [CNT_W-1:0] pos_q, pos_d;
  logic             half_q, half_d;
  logic             half_last;

  assign half_last = (pos_q == half_len - CNT_W'(1));

  always_comb begin
    pos_d  = pos_q;
    half_d = half_q;
    if (!run_i) begin
      pos_d  = '0;
      half_d = 1'b0;
    end else if (tick_i) begin
      if (half_last) begin
        pos_d  = '0;
        half_d = ~half_q;
      end else begin
        pos_d  = pos_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      half_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      half_q <= half_d;
    end
  end

  assign period_end_o = run_i && tick_i && half_last && half_q;
  assign pol_a_o      = run_i && (pos_q != '0) && !half_q;
  assign pol_b_o      = run_i && (pos_q != '0) && half_q;
endmodule

// File: rtl/lra_phase_fsm.sv
module lra_phase_fsm
  import lra_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SU_W      = 4,
  parameter int BRAKE_CAP = 3000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ready_i,
  input  logic             en_i,
  input  logic             period_end_i,
  input  logic [SU_W-1:0]  startup_per_i,
  input  logic [CNT_W-1:0] brake_cfg_i,
  output phase_e           phase_o,
  output logic             brake_drive_o
);
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(BRAKE_CAP);

  phase_e           phase_q, phase_d;
  logic [SU_W-1:0]  scnt_q, scnt_d;
  logic [CNT_W-1:0] dcnt_q, dcnt_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic [CNT_W-1:0] blen_q, blen_d;
  logic             pend_q, pend_d;
  logic             en_prev_q;

  logic             rise;
  logic [CNT_W-1:0] d_sat;
  logic [SU_W-1:0]  su_eff;
  logic [CNT_W-1:0] blen_new;

  assign rise     = en_i && !en_prev_q;
  assign d_sat    = (dcnt_q >= CAP_V) ? CAP_V : dcnt_q + CNT_W'(1);
  assign su_eff   = (startup_per_i == '0) ? SU_W'(1) : startup_per_i;
  assign blen_new = (brake_cfg_i != '0) ? brake_cfg_i : d_sat;

  always_comb begin
    phase_d = phase_q;
    scnt_d  = scnt_q;
    dcnt_d  = dcnt_q;
    bcnt_d  = bcnt_q;
    blen_d  = blen_q;
    pend_d  = pend_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (ready_i && rise) pend_d = 1'b1;
        if (tick_i && ready_i && (en_i || pend_q || rise)) begin
          phase_d = PH_START;
          scnt_d  = '0;
          dcnt_d  = '0;
          pend_d  = 1'b0;
        end
      end
      PH_START: begin
        if (tick_i) dcnt_d = d_sat;
        if (period_end_i) begin
          if (!en_i) begin
            phase_d = PH_BRAKE;
            bcnt_d  = '0;
            blen_d  = blen_new;
            pend_d  = 1'b0;
          end else if (scnt_q + SU_W'(1) >= su_eff) begin
            phase_d = PH_DRIVE;
          end else begin
            scnt_d  = scnt_q + SU_W'(1);
          end
        end
      end
      PH_DRIVE: begin
        if (tick_i) dcnt_d = d_sat;
        if (period_end_i && !en_i) begin
          phase_d = PH_BRAKE;
          bcnt_d  = '0;
          blen_d  = blen_new;
          pend_d  = 1'b0;
        end
      end
      PH_BRAKE: begin
        if (rise) pend_d = 1'b1;
        if (tick_i) begin
          if (bcnt_q == blen_q - CNT_W'(1)) begin
            pend_d = 1'b0;
            if (pend_q || rise) begin
              phase_d = PH_START;
              scnt_d  = '0;
              dcnt_d  = '0;
            end else begin
              phase_d = PH_IDLE;
            end
          end else begin
            bcnt_d = bcnt_q + CNT_W'(1);
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      scnt_q    <= '0;
      dcnt_q    <= '0;
      bcnt_q    <= '0;
      blen_q    <= CNT_W'(1);
      pend_q    <= 1'b0;
      en_prev_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      scnt_q    <= scnt_d;
      dcnt_q    <= dcnt_d;
      bcnt_q    <= bcnt_d;
      blen_q    <= blen_d;
      pend_q    <= pend_d;
      en_prev_q <= en_i;
    end
  end

  assign phase_o       = phase_q;
  assign brake_drive_o = (phase_q == PH_BRAKE) && (bcnt_q != '0);
endmodule

// File: rtl/lra_drive_seq.sv
module lra_drive_seq
  import lra_seq_pkg::*;
#(
  parameter int TICK_DIV   = 1250,
  parameter int FC_W       = 5,
  parameter int CNT_W      = 16,
  parameter int SU_W       = 4,
  parameter int AMP_W      = 4,
  parameter int HALF_MIN   = 130,
  parameter int HALF_STEP  = 6,
  parameter int BRAKE_CAP  = 3000,
  parameter int LOCK_TICKS = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SU_W-1:0]  startup_per_i,
  input  logic [CNT_W-1:0] brake_cfg_i,
  input  logic [AMP_W-1:0] amp_cfg_i,
  input  logic [FC_W-1:0]  freq_code_i,
  output logic             hb_a_o,
  output logic             hb_b_o,
  output logic [AMP_W-1:0] amp_o,
  output logic [1:0]       phase_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic   tick, ready, run, period_end, wave_a, wave_b, brake_drive;
  phase_e phase;

  lra_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk), .rst_ni (rst_core_n), .tick_o (tick)
  );

  lra_lockout #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
    .clk_i (clk), .rst_ni (rst_core_n), .tick_i (tick), .ready_o (ready)
  );

  assign run = (phase == PH_START) || (phase == PH_DRIVE);

  lra_wave_gen #(
    .FC_W (FC_W), .CNT_W (CNT_W), .HALF_MIN (HALF_MIN), .HALF_STEP (HALF_STEP)
  ) u_wave (
    .clk_i        (clk),
    .rst_ni       (rst_core_n),
    .tick_i       (tick),
    .run_i        (run),
    .freq_code_i  (freq_code_i),
    .pol_a_o      (wave_a),
    .pol_b_o      (wave_b),
    .period_end_o (period_end)
  );

  lra_phase_fsm #(
    .CNT_W (CNT_W), .SU_W (SU_W), .BRAKE_CAP (BRAKE_CAP)
  ) u_fsm (
    .clk_i         (clk),
    .rst_ni        (rst_core_n),
    .tick_i        (tick),
    .ready_i       (ready),
    .en_i          (en_i),
    .period_end_i  (period_end),
    .startup_per_i (startup_per_i),
    .brake_cfg_i   (brake_cfg_i),
    .phase_o       (phase),
    .brake_drive_o (brake_drive)
  );

  always_comb begin
    unique case (phase)
      PH_START, PH_BRAKE: amp_o = '1;
      PH_DRIVE:           amp_o = amp_cfg_i;
      default:            amp_o = '0;
    endcase
  end

  assign hb_a_o  = wave_a || brake_drive;
  assign hb_b_o  = wave_b;
  assign phase_o = phase;
endmodule

// File: rtl/lra_seq_chk.sv
module lra_seq_chk
  import lra_seq_pkg::*;
#(
  parameter int AMP_W      = 4,
  parameter int LOCK_TICKS = 20000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             hb_a_o,
  input logic             hb_b_o,
  input logic [AMP_W-1:0] amp_o,
  input logic [AMP_W-1:0] amp_cfg_i,
  input logic [1:0]       phase_o
);
  localparam int LK_W = $clog2(LOCK_TICKS + 1);
  localparam logic [LK_W-1:0] LOCK_V = LK_W'(LOCK_TICKS);

  logic [LK_W-1:0] lk_cnt;
  logic            past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_cnt  <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (tick && (lk_cnt != LOCK_V)) lk_cnt <= lk_cnt + LK_W'(1);
    end
  end

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hb_a_o && hb_b_o));

  a_r6_dead_ab: assert property (@(posedge clk) disable iff (!rst_n)
    hb_a_o |=> !hb_b_o);

  a_r6_dead_ba: assert property (@(posedge clk) disable iff (!rst_n)
    hb_b_o |=> !hb_a_o);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_IDLE) |-> (!hb_a_o && !hb_b_o && amp_o == '0));

  a_r10_brake_pol: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_BRAKE) |-> (!hb_b_o && amp_o == '1));

  a_r4_drive_amp: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_DRIVE) |-> (amp_o == amp_cfg_i));

  a_r2_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_cnt != LOCK_V) |-> (phase_o == PH_IDLE));

  a_r3_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(phase_o) == PH_IDLE && phase_o != PH_IDLE) |-> (phase_o == PH_START));

  a_r11_brake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(phase_o) == PH_BRAKE && phase_o != PH_BRAKE)
      |-> (phase_o == PH_IDLE || phase_o == PH_START));
endmodule

bind lra_drive_seq lra_seq_chk #(
  .AMP_W (AMP_W), .LOCK_TICKS (LOCK_TICKS)
) u_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .hb_a_o    (hb_a_o),
  .hb_b_o    (hb_b_o),
  .amp_o     (amp_o),
  .amp_cfg_i (amp_cfg_i),
  .phase_o   (phase_o)
);

// File: tb/tb_lra_drive_seq.sv
module tb_lra_drive_seq;
  localparam int DIV = 4, FC_W = 5, CNT_W = 16, SU_W = 4, AMP_W = 4;
  localparam int HMIN = 3, HSTEP = 1, CAP = 60, LOCK = 50;
  localparam int D_ANY = -3, D_PER = -1, D_AUTO = -2;
  localparam int AMAX = (1 << AMP_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [SU_W-1:0]  su = 4'd2;
  logic [CNT_W-1:0] bcfg = '0;
  logic [AMP_W-1:0] amp = 4'd5;
  logic [FC_W-1:0]  fc = 5'd2;
  logic hb_a, hb_b;
  logic [AMP_W-1:0] amp_o;
  logic [1:0] ph;

  always #4 clk = ~clk;

  lra_drive_seq #(
    .TICK_DIV(DIV), .FC_W(FC_W), .CNT_W(CNT_W), .SU_W(SU_W), .AMP_W(AMP_W),
    .HALF_MIN(HMIN), .HALF_STEP(HSTEP), .BRAKE_CAP(CAP), .LOCK_TICKS(LOCK)
  ) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .startup_per_i(su), .brake_cfg_i(bcfg),
    .amp_cfg_i(amp), .freq_code_i(fc), .hb_a_o(hb_a), .hb_b_o(hb_b),
    .amp_o(amp_o), .phase_o(ph)
  );

  int n_chk = 0, n_fail = 0;
  int qph[$], qdur[$];
  string qtag[$];
  int half_t = HMIN + 2 * HSTEP;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(int p, int d, string tag);
    qph.push_back(p); qdur.push_back(d); qtag.push_back(tag);
  endtask

  int cur_ph = 0, seglen = 0, act_k = 0, drive_acc = 0;
  bit wave_bad = 0, amp_bad = 0, ovl_bad = 0;

  task automatic close_seg();
    int ep, ed, exp_len;
    string et;
    string wt;
    if (qph.size() == 0) begin
      chk(0, "R11", "unexpected segment phase", cur_ph, -1);
    end else begin
      ep = qph.pop_front(); ed = qdur.pop_front(); et = qtag.pop_front();
      chk(ep == cur_ph, et, "segment phase", cur_ph, ep);
      if (ed == D_PER) begin
        chk(seglen > 0 && seglen % (2 * half_t * DIV) == 0, et, "whole periods length",
            seglen, 2 * half_t * DIV);
      end else if (ed == D_AUTO) begin
        exp_len = ((drive_acc / DIV) < CAP ? (drive_acc / DIV) : CAP) * DIV;
        chk(seglen == exp_len, et, "adaptive brake length", seglen, exp_len);
      end else if (ed != D_ANY) begin
        chk(seglen == ed, et, "segment length", seglen, ed);
      end
    end
    wt = (cur_ph == 3) ? "R10" : (cur_ph == 0) ? "R1" : "R6";
    chk(!wave_bad, wt, "bridge waveform", wave_bad, 0);
    chk(!amp_bad, (cur_ph == 2) ? "R4" : (cur_ph == 0) ? "R1" : "R3", "amplitude", amp_bad, 0);
    chk(!ovl_bad, "R7", "outputs overlap", ovl_bad, 0);
    if (cur_ph == 1 || cur_ph == 2) drive_acc += seglen;
    if (cur_ph == 3) drive_acc = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      cur_ph = 0; seglen = 0; act_k = 0; drive_acc = 0;
    end else begin
      int t, p, hf, eamp;
      bit ea, eb;
      if (int'(ph) != cur_ph) begin
        close_seg();
        cur_ph = int'(ph); seglen = 0;
        wave_bad = 0; amp_bad = 0; ovl_bad = 0;
        if (cur_ph == 1) act_k = 0;
      end
      ea = 0; eb = 0; eamp = 0;
      case (cur_ph)
        1, 2: begin
          t = act_k / DIV; p = t % half_t; hf = (t / half_t) % 2;
          ea = (p != 0) && (hf == 0); eb = (p != 0) && (hf == 1);
          act_k++;
          eamp = (cur_ph == 1) ? AMAX : int'(amp);
        end
        3: begin ea = (seglen / DIV) != 0; eamp = AMAX; end
        default: ;
      endcase
      if (hb_a !== ea || hb_b !== eb) wave_bad = 1;
      if (hb_a && hb_b) ovl_bad = 1;
      if (int'(amp_o) != eamp) amp_bad = 1;
      seglen++;
    end
  end

  task automatic settle();
    while (!(qph.size() == 1 && ph == 2'd0)) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic pulse(int clks);
    @(negedge clk); en = 1'b1;
    repeat (clks) @(negedge clk);
    en = 1'b0;
  endtask

  bit done = 0;

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      chk(0, "R1", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    push(0, D_ANY, "R2");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ph == 2'd0, "R1", "reset phase", ph, 0);
    chk(!hb_a && !hb_b, "R1", "reset bridge", {hb_a, hb_b}, 0);
    chk(amp_o == '0, "R1", "reset amplitude", amp_o, 0);
    // R2: enable activity inside the lockout window
    repeat (30) @(negedge clk);
    pulse(60);
    repeat (150) @(negedge clk);
    chk(ph == 2'd0, "R2", "phase after lockout window", ph, 0);
    repeat (40) @(negedge clk);

    // R3 R4 R8: long burst, brake capped
    push(1, 80, "R3"); push(2, D_PER, "R4"); push(3, D_AUTO, "R8"); push(0, D_ANY, "R1");
    pulse(300);
    settle();

    // R8: burst below the cap
    push(1, 80, "R3"); push(2, D_PER, "R4"); push(3, D_AUTO, "R8"); push(0, D_ANY, "R1");
    pulse(140);
    settle();

    // R5: single-clock pulse gives one period
    push(1, 2 * half_t * DIV, "R5"); push(3, D_AUTO, "R8"); push(0, D_ANY, "R1");
    pulse(1);
    settle();

    // R11: edge during brake restarts without idle
    push(1, 80, "R3"); push(2, D_PER, "R4"); push(3, D_AUTO, "R8");
    push(1, 2 * half_t * DIV, "R11"); push(3, D_AUTO, "R11"); push(0, D_ANY, "R11");
    pulse(140);
    while (ph != 2'd3) @(negedge clk);
    repeat (8) @(negedge clk);
    pulse(1);
    settle();

    // R9: fixed brake length
    bcfg = 16'd7;
    push(1, 2 * half_t * DIV, "R5"); push(3, 7 * DIV, "R9"); push(0, D_ANY, "R1");
    pulse(1);
    settle();
    bcfg = '0;

    // R6: other frequency code
    fc = 5'd6; half_t = HMIN + 6 * HSTEP;
    push(1, 2 * half_t * DIV, "R6"); push(3, D_AUTO, "R8"); push(0, D_ANY, "R1");
    pulse(2);
    settle();

    chk(qph.size() == 1, "R11", "scoreboard leftover items", qph.size(), 1);
    chk(ph == 2'd0, "R1", "final phase", ph, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule